// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for a shared packet memory cut into fixed 256-byte pages. A host asks for room by page count and gets back a packet number. It then uses that same number to queue the packet for sending and to give the pages back once the packet has gone out. The block holds three small queues of packet numbers: packets waiting to transmit, packets whose transmission has completed, and packets that the receive side has stored. It does not touch the memory contents. A transmitter takes waiting packet numbers from a valid/ready stream, and each accepted transfer counts as one completed transmission.

The host issues commands through a plain strobe with a 3-bit opcode: 1 reset pool, 2 allocate, 3 free selected packet, 4 enqueue selected packet for transmit, 5 release head of receive queue, 6 pop completion queue. Opcodes 0 and 7 do nothing. An allocation occupies the block for `ALLOC_LAT` cycles. A receiver pushes incoming frames in on a valid/ready stream that carries a page count. The receiver holds `rx_in_valid` and its page count until `rx_in_ready` is seen high. The block deasserts `rx_in_ready` while an allocation is in flight and in any cycle in which the host strobes a command. On the transmit stream, the block holds `tx_out_valid` and `tx_out_pkt` steady until `tx_out_ready` is sampled high.

Top module: `pktbuf_mmu`

## Requirements
- R1: An allocation (opcode 2) with page field c asks for c+1 pages out of `TOTAL_PAGES`. It succeeds only when an unused packet number exists and at least c+1 pages are free. A successful allocation removes those pages from the free pool.
- R2: A successful allocation hands out the lowest unused packet number.
- R3: `alloc_result` is 0x80 after reset. A finished host allocation sets it to {0, packet number} on success and to 0x80 on failure. No other command changes it.
- R4: `alloc_irq` goes to 1 when a host allocation finishes, whether it passed or failed. A one-cycle pulse on `ack_alloc` clears it. If both happen in the same cycle, setting wins.
- R5: `busy` is high for exactly `ALLOC_LAT` cycles, starting the cycle after the request is sampled. The result and `alloc_irq` are valid once `busy` falls.
- R6: Host commands strobed while `busy` is high are ignored. `rx_in_ready` is low while busy or while `cmd_wr` is high.
- R7: Free (opcode 3) returns all pages of the selected packet to the pool and makes its number reusable. Freeing a number that is not allocated has no effect.
- R8: Enqueue (opcode 4) appends `sel_pkt` to the transmit queue, and `tx_out` presents that queue in order. Each handshake moves the head into the completion queue and sets `tx_irq`, which `ack_tx` clears. `done_head` shows the head of the completion queue with bit 7 set when the queue is empty. Opcode 6 pops that queue.
- R9: An accepted receive frame is allocated like a host request. On success its number joins the receive queue, `rx_empty` drops and `rx_head` shows the oldest entry. On failure the frame is dropped. Neither outcome affects `alloc_result` or `alloc_irq`.
- R10: Release (opcode 5) pops the head of the receive queue and frees its pages. With an empty receive queue it has no effect.
- R11: Reset pool (opcode 1) marks every page and packet number free and empties all three queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_pages | input | 3 | Page field for allocate (pages minus one) |
| sel_pkt | input | 7 | Selected packet number for free and enqueue |
| ack_alloc | input | 1 | Clears alloc_irq |
| ack_tx | input | 1 | Clears tx_irq |
| busy | output | 1 | Allocation in progress |
| alloc_result | output | 8 | Bit 7 failure flag, bits 6:0 packet number |
| alloc_irq | output | 1 | Host allocation finished |
| tx_irq | output | 1 | A transmission completed |
| done_head | output | 8 | Completion queue head, bit 7 set when empty |
| rx_in_valid | input | 1 | Receive frame offered |
| rx_in_pages | input | 3 | Receive frame page field (pages minus one) |
| rx_in_ready | output | 1 | Receive frame accepted |
| rx_empty | output | 1 | Receive queue empty |
| rx_head | output | 7 | Oldest received packet number |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_pkt | output | 7 | Packet number at transmit queue head |
| tx_out_ready | input | 1 | Transmission of head complete |

## Verification
Errors in the ownership state surface at the ports through the next allocation. A leaked or double-counted page turns an allocation that should pass into one that fails, or the reverse. A stale ownership bit hands out the wrong lowest packet number. Either error shows up in `alloc_result` exactly `ALLOC_LAT` cycles after the request. A queue pointer fault shows on the cycle after the enqueue, handshake or release, as a wrong head number or a wrong empty flag.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_RESET   = 3'd1,
    OP_ALLOC   = 3'd2,
    OP_FREE    = 3'd3,
    OP_ENQ     = 3'd4,
    OP_RELEASE = 3'd5,
    OP_POPDONE = 3'd6
  } mmu_op_e;

  localparam int PKT_FIELD_W = 7;
  localparam int PAGE_FIELD_W = 3;
endpackage

// File: rtl/pktbuf_fifo.sv
module pktbuf_fifo #(
  parameter int W = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop) cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  // R8: occupancy never exceeds the storage
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R11: a clear leaves the queue empty on the next cycle
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/pktbuf_pool.sv
module pktbuf_pool #(
  parameter int NUM_PKT = 8,
  parameter int TOTAL_PAGES = 18,
  parameter int PN_W = 3,
  parameter int NEED_W = 4,
  parameter int FP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              grant,
  input  logic [NEED_W-1:0] need,
  input  logic              rel,
  input  logic [PN_W-1:0]   rel_pkt,
  output logic              found,
  output logic [PN_W-1:0]   low_pkt,
  output logic [FP_W-1:0]   free_pages
);
  logic [NUM_PKT-1:0] inuse;
  logic [NEED_W-1:0]  npg [NUM_PKT];
  logic               rel_hit;
  logic [NEED_W-1:0]  rel_pg;

  // lowest unused packet number
  always_comb begin
    found   = 1'b0;
    low_pkt = '0;
    for (int i = NUM_PKT - 1; i >= 0; i--) begin
      if (!inuse[i]) begin
        found   = 1'b1;
        low_pkt = PN_W'(i);
      end
    end
  end

  assign rel_hit = rel && (int'(rel_pkt) < NUM_PKT) && inuse[rel_pkt];
  assign rel_pg  = npg[rel_pkt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inuse      <= '0;
      free_pages <= FP_W'(TOTAL_PAGES);
      for (int i = 0; i < NUM_PKT; i++) npg[i] <= '0;
    end else if (clr) begin
      inuse      <= '0;
      free_pages <= FP_W'(TOTAL_PAGES);
    end else if (grant && found) begin
      inuse[low_pkt] <= 1'b1;
      npg[low_pkt]   <= need;
      free_pages     <= free_pages - FP_W'(need);
    end else if (rel_hit) begin
      inuse[rel_pkt] <= 1'b0;
      free_pages     <= free_pages + FP_W'(rel_pg);
    end
  end

  // R1: the pool never holds more pages than exist
  assert_pages_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    free_pages <= FP_W'(TOTAL_PAGES));

  // R1: a grant is only requested when it can be covered
  assert_grant_covered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (found && (FP_W'(need) <= free_pages)));

  // R7: releases never coincide with a grant
  assert_no_grant_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && rel));
endmodule

// File: rtl/pktbuf_mmu.sv
module pktbuf_mmu #(
  parameter int NUM_PKT = 8,
  parameter int TOTAL_PAGES = 18,
  parameter int ALLOC_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [2:0] cmd_op,
  input  logic [2:0] cmd_pages,
  input  logic [6:0] sel_pkt,
  input  logic       ack_alloc,
  input  logic       ack_tx,
  output logic       busy,
  output logic [7:0] alloc_result,
  output logic       alloc_irq,
  output logic       tx_irq,
  output logic [7:0] done_head,
  input  logic       rx_in_valid,
  input  logic [2:0] rx_in_pages,
  output logic       rx_in_ready,
  output logic       rx_empty,
  output logic [6:0] rx_head,
  output logic       tx_out_valid,
  output logic [6:0] tx_out_pkt,
  input  logic       tx_out_ready
);
  import pktbuf_pkg::*;

  localparam int PN_W   = (NUM_PKT > 1) ? $clog2(NUM_PKT) : 1;
  localparam int NEED_W = PAGE_FIELD_W + 1;
  localparam int FP_W   = $clog2(TOTAL_PAGES + 1);
  localparam int CNT_W  = (ALLOC_LAT > 1) ? $clog2(ALLOC_LAT) : 1;

  mmu_op_e op;
  logic    cmd_go, sel_ok;
  logic    req_reset, req_alloc, req_free, req_enq, req_rel, req_pop;
  logic [PN_W-1:0] sel_idx;

  assign op        = mmu_op_e'(cmd_op);
  assign cmd_go    = cmd_wr && !busy;
  assign sel_ok    = int'(sel_pkt) < NUM_PKT;
  assign sel_idx   = sel_pkt[PN_W-1:0];
  assign req_reset = cmd_go && (op == OP_RESET);
  assign req_alloc = cmd_go && (op == OP_ALLOC);
  assign req_free  = cmd_go && (op == OP_FREE);
  assign req_enq   = cmd_go && (op == OP_ENQ);
  assign req_rel   = cmd_go && (op == OP_RELEASE);
  assign req_pop   = cmd_go && (op == OP_POPDONE);

  // receive stream: host commands take priority
  logic rx_go;
  assign rx_in_ready = !busy && !cmd_wr;
  assign rx_go       = rx_in_valid && rx_in_ready;

  // allocation sequencer
  logic              start, src_rx_q, finish;
  logic [CNT_W-1:0]  lat_cnt;
  logic [NEED_W-1:0] need_q, start_need;

  assign start      = req_alloc || rx_go;
  assign start_need = NEED_W'(rx_go ? rx_in_pages : cmd_pages) + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      lat_cnt  <= '0;
      need_q   <= '0;
      src_rx_q <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      lat_cnt  <= CNT_W'(ALLOC_LAT - 1);
      need_q   <= start_need;
      src_rx_q <= rx_go;
    end else if (busy) begin
      if (lat_cnt == '0) busy <= 1'b0;
      else lat_cnt <= lat_cnt - 1'b1;
    end
  end

  assign finish = busy && (lat_cnt == '0);

  // ownership pool
  logic            found, grant, rel;
  logic [PN_W-1:0] low_pkt, rel_pkt;
  logic [FP_W-1:0] free_pages;
  logic            rxq_empty, rxq_full;
  logic [PN_W-1:0] rxq_head;

  assign grant   = finish && found && (free_pages >= FP_W'(need_q));
  assign rel     = (req_free && sel_ok) || (req_rel && !rxq_empty);
  assign rel_pkt = req_rel ? rxq_head : sel_idx;

  pktbuf_pool #(
    .NUM_PKT(NUM_PKT), .TOTAL_PAGES(TOTAL_PAGES), .PN_W(PN_W),
    .NEED_W(NEED_W), .FP_W(FP_W)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .clr(req_reset),
    .grant(grant), .need(need_q),
    .rel(rel), .rel_pkt(rel_pkt),
    .found(found), .low_pkt(low_pkt), .free_pages(free_pages)
  );

  // packet-number queues
  logic            txq_empty, txq_full, doneq_empty, doneq_full, tx_hs;
  logic [PN_W-1:0] txq_head, doneq_head;

  assign tx_hs = tx_out_valid && tx_out_ready;

  pktbuf_fifo #(.W(PN_W), .DEPTH(NUM_PKT)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(req_reset),
    .push(grant && src_rx_q), .din(low_pkt),
    .pop(req_rel), .dout(rxq_head), .empty(rxq_empty), .full(rxq_full)
  );

  pktbuf_fifo #(.W(PN_W), .DEPTH(NUM_PKT)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(req_reset),
    .push(req_enq && sel_ok), .din(sel_idx),
    .pop(tx_hs), .dout(txq_head), .empty(txq_empty), .full(txq_full)
  );

  pktbuf_fifo #(.W(PN_W), .DEPTH(NUM_PKT)) u_doneq (
    .clk(clk), .rst_n(rst_n), .clr(req_reset),
    .push(tx_hs), .din(txq_head),
    .pop(req_pop), .dout(doneq_head), .empty(doneq_empty), .full(doneq_full)
  );

  assign rx_empty     = rxq_empty;
  assign rx_head      = PKT_FIELD_W'(rxq_head);
  assign tx_out_valid = !txq_empty;
  assign tx_out_pkt   = PKT_FIELD_W'(txq_head);
  assign done_head    = doneq_empty ? 8'h80 : {1'b0, PKT_FIELD_W'(doneq_head)};

  // host-visible status
  logic host_fin;
  assign host_fin = finish && !src_rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_result <= 8'h80;
      alloc_irq    <= 1'b0;
      tx_irq       <= 1'b0;
    end else begin
      if (host_fin) alloc_result <= grant ? {1'b0, PKT_FIELD_W'(low_pkt)} : 8'h80;
      if (host_fin) alloc_irq <= 1'b1;
      else if (ack_alloc) alloc_irq <= 1'b0;
      if (tx_hs) tx_irq <= 1'b1;
      else if (ack_tx) tx_irq <= 1'b0;
    end
  end

  // R3: a failure flag never carries a packet number
  assert_result_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_result[7] |-> (alloc_result[6:0] == '0));

  // R4: a finished host allocation raises the interrupt bit
  assert_alloc_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_fin |=> alloc_irq);

  // R5: busy does not drop before the countdown ends
  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  // R6: a strobe during busy leaves the completion queue untouched
  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && !tx_hs) |=> $stable(done_head));

  // R8: every transmit handshake raises the transmit interrupt bit
  assert_tx_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hs |=> tx_irq);

  // R9: receive allocations leave the host result alone
  assert_rx_keeps_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && src_rx_q) |=> $stable(alloc_result));

  // R11: a pool reset empties every queue
  assert_reset_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_reset |=> (rx_empty && !tx_out_valid && done_head[7]));
endmodule

// File: tb/pktbuf_mmu_test.sv
module pktbuf_mmu_test;
  localparam int ALLOC_LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr;
  logic [2:0] cmd_op, cmd_pages;
  logic [6:0] sel_pkt;
  logic       ack_alloc, ack_tx;
  logic       busy, alloc_irq, tx_irq;
  logic [7:0] alloc_result, done_head;
  logic       rx_in_valid, rx_in_ready, rx_empty;
  logic [2:0] rx_in_pages;
  logic [6:0] rx_head;
  logic       tx_out_valid, tx_out_ready;
  logic [6:0] tx_out_pkt;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pktbuf_mmu #(.NUM_PKT(8), .TOTAL_PAGES(18), .ALLOC_LAT(ALLOC_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .cmd_pages(cmd_pages), .sel_pkt(sel_pkt), .ack_alloc(ack_alloc),
    .ack_tx(ack_tx), .busy(busy), .alloc_result(alloc_result),
    .alloc_irq(alloc_irq), .tx_irq(tx_irq), .done_head(done_head),
    .rx_in_valid(rx_in_valid), .rx_in_pages(rx_in_pages),
    .rx_in_ready(rx_in_ready), .rx_empty(rx_empty), .rx_head(rx_head),
    .tx_out_valid(tx_out_valid), .tx_out_pkt(tx_out_pkt),
    .tx_out_ready(tx_out_ready)
  );

  // {op[3], pages[3], sel[7], expected result[8]}
  localparam logic [20:0] VEC [10] = '{
    {3'd2, 3'd2, 7'd0, 8'h00},
    {3'd2, 3'd7, 7'd0, 8'h01},
    {3'd2, 3'd7, 7'd0, 8'h80},
    {3'd2, 3'd6, 7'd0, 8'h02},
    {3'd3, 3'd0, 7'd1, 8'h02},
    {3'd2, 3'd0, 7'd0, 8'h01},
    {3'd2, 3'd6, 7'd0, 8'h03},
    {3'd2, 3'd0, 7'd0, 8'h80},
    {3'd3, 3'd0, 7'd0, 8'h80},
    {3'd2, 3'd2, 7'd0, 8'h00}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] pg, input logic [6:0] sel);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_op = op; cmd_pages = pg; sel_pkt = sel;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic settle();
    repeat (ALLOC_LAT + 1) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_alloc = 1'b1;
    @(negedge clk); ack_alloc = 1'b0;
  endtask

  task automatic do_alloc(input logic [2:0] pg, input logic [7:0] exp, input string tag);
    cmd(3'd2, pg, 7'd0);
    settle();
    chk(alloc_result == exp, tag, alloc_result, exp);
    chk(alloc_irq == 1'b1, {tag, " R4 irq"}, alloc_irq, 1);
    pulse_ack();
  endtask

  task automatic rx_push(input logic [2:0] pg);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_pages = pg;
    chk(rx_in_ready == 1'b1, "R6 rx ready when idle", rx_in_ready, 1);
    @(negedge clk);
    rx_in_valid = 1'b0;
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_op = '0; cmd_pages = '0; sel_pkt = '0;
    ack_alloc = 1'b0; ack_tx = 1'b0; rx_in_valid = 1'b0; rx_in_pages = '0;
    tx_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(alloc_result == 8'h80, "R3 reset result", alloc_result, 8'h80);
    chk(alloc_irq == 1'b0, "R4 reset irq", alloc_irq, 0);
    chk(busy == 1'b0, "R5 reset busy", busy, 0);
    chk(rx_empty == 1'b1, "R9 reset rx_empty", rx_empty, 1);
    chk(tx_out_valid == 1'b0 && tx_irq == 1'b0, "R8 reset tx", {tx_out_valid, tx_irq}, 0);
    chk(done_head == 8'h80, "R8 reset done_head", done_head, 8'h80);
    chk(rx_in_ready == 1'b1, "R6 reset rx_in_ready", rx_in_ready, 1);

    // table: allocations and frees against 18 pages
    for (int i = 0; i < 10; i++) begin
      cmd(VEC[i][20:18], VEC[i][17:15], VEC[i][14:8]);
      settle();
      if (VEC[i][20:18] == 3'd2) begin
        chk(alloc_result == VEC[i][7:0], "R1 R2 R3 table alloc", alloc_result, VEC[i][7:0]);
        chk(alloc_irq == 1'b1, "R4 irq after table alloc", alloc_irq, 1);
        pulse_ack();
        chk(alloc_irq == 1'b0, "R4 irq cleared by ack", alloc_irq, 0);
      end else begin
        chk(alloc_result == VEC[i][7:0], "R3 R7 free keeps result", alloc_result, VEC[i][7:0]);
      end
    end

    // enqueue order, then pool reset
    cmd(3'd4, 3'd0, 7'd2);
    cmd(3'd4, 3'd0, 7'd0);
    chk(tx_out_valid == 1'b1 && tx_out_pkt == 7'd2, "R8 tx head after enqueue", tx_out_pkt, 2);
    cmd(3'd1, 3'd0, 7'd0);
    chk(rx_empty == 1'b1 && tx_out_valid == 1'b0, "R11 queues empty", {rx_empty, tx_out_valid}, 2);
    chk(done_head == 8'h80, "R11 done queue empty", done_head, 8'h80);
    do_alloc(3'd7, 8'h00, "R11 pool restored");

    // busy timing
    cmd(3'd2, 3'd0, 7'd0);
    chk(busy == 1'b1, "R5 busy first cycle", busy, 1);
    for (int i = 1; i < ALLOC_LAT; i++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R5 busy held", busy, 1);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R5 busy dropped", busy, 0);
    chk(alloc_result == 8'h01 && alloc_irq == 1'b1, "R5 result at end", alloc_result, 8'h01);
    pulse_ack();

    // command during busy is ignored
    cmd(3'd2, 3'd0, 7'd0);
    chk(rx_in_ready == 1'b0, "R6 rx_in_ready low while busy", rx_in_ready, 0);
    cmd(3'd3, 3'd0, 7'd1);
    settle();
    chk(alloc_result == 8'h02, "R6 alloc during ignored free", alloc_result, 8'h02);
    pulse_ack();
    do_alloc(3'd0, 8'h03, "R6 free while busy ignored");

    // free of an unused number
    cmd(3'd3, 3'd0, 7'd5);
    do_alloc(3'd6, 8'h04, "R7 fill remaining pages");
    do_alloc(3'd0, 8'h80, "R7 unused free adds no pages");

    // transmit path
    cmd(3'd4, 3'd0, 7'd3);
    cmd(3'd4, 3'd0, 7'd1);
    chk(tx_out_valid == 1'b1 && tx_out_pkt == 7'd3, "R8 first queued", tx_out_pkt, 3);
    chk(done_head == 8'h80, "R8 no completion yet", done_head, 8'h80);
    @(negedge clk); tx_out_ready = 1'b1;
    @(negedge clk); tx_out_ready = 1'b0;
    chk(tx_irq == 1'b1, "R8 tx_irq set", tx_irq, 1);
    chk(done_head == 8'h03, "R8 completion head", done_head, 8'h03);
    chk(tx_out_pkt == 7'd1, "R8 fifo order", tx_out_pkt, 1);
    @(negedge clk); ack_tx = 1'b1;
    @(negedge clk); ack_tx = 1'b0;
    chk(tx_irq == 1'b0, "R8 tx_irq cleared", tx_irq, 0);
    cmd(3'd6, 3'd0, 7'd0);
    chk(done_head == 8'h80, "R8 completion popped", done_head, 8'h80);
    cmd(3'd3, 3'd0, 7'd3);
    do_alloc(3'd0, 8'h03, "R2 R7 freed number reused");

    // receive path
    cmd(3'd3, 3'd0, 7'd4);
    rx_push(3'd1);
    chk(rx_empty == 1'b0 && rx_head == 7'd4, "R9 rx queued", rx_head, 4);
    chk(alloc_result == 8'h03 && alloc_irq == 1'b0, "R9 host status untouched", alloc_result, 8'h03);
    rx_push(3'd7);
    chk(rx_head == 7'd4, "R9 oversize frame dropped", rx_head, 4);
    cmd(3'd5, 3'd0, 7'd0);
    chk(rx_empty == 1'b1, "R9 R10 only one entry queued", rx_empty, 1);
    do_alloc(3'd6, 8'h04, "R10 release returned pages");
    cmd(3'd5, 3'd0, 7'd0);
    do_alloc(3'd0, 8'h80, "R10 empty release no effect");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule